// File: doc/BRIEF.md
# Mailbox Ownership Semaphore Arbiter

This block decides which of two agents, a host reached over a byte-wide register bus and an on-chip device processor with its own byte-wide register port, may use each of three shared mailbox memories. Every mailbox has a 2-bit ownership code. An agent asks for a mailbox by writing its request code into that mailbox's semaphore, then reads the semaphore back. The code it reads names the current owner.

A request that cannot be served at once because the other agent holds the mailbox is remembered. It is granted when the holder releases. If both agents ask for a free mailbox in the same cycle, the host gets it and the device request waits. When the host obtains a mailbox by taking over from the device, a sticky per-mailbox "granted" flag is set. Each flag reaches the host interrupt line only when its enable bit is set. The enables form an 11-bit register split across two host byte addresses, and only the top three bits drive this block's interrupt.

Top module: `mbx_sema_arbiter`

## Requirements
- R1: Under reset (rst_n low at a clock edge) every ownership code becomes 2'b00 (free), all 11 enable bits and all three granted flags become 0, and host_irq is 0.
- R2: The host reads semaphore i at address 0x1C+i and the device reads it at address 0x00+i, each in bits 1:0 with bits 7:2 read as 0. Owner codes are 2'b00 free, 2'b01 host, 2'b11 device. A read of an unmapped address returns 0x00.
- R3: A host write of 2'b01 in bits 1:0 to a free semaphore makes the host the owner. A device write of 2'b11 to a free semaphore makes the device the owner.
- R4: A request to a semaphore held by the other agent leaves the owner unchanged and is kept pending. When the holder writes 2'b00, ownership passes to the pending agent.
- R5: When both agents request the same free semaphore in one cycle, the host becomes owner and the device request stays pending.
- R6: A release written by the agent that does not own the semaphore, and any written code other than that agent's request or release code (host 2'b10 or 2'b11, device 2'b01 or 2'b10), leaves the semaphore unchanged.
- R7: A release by the owner with no request pending makes the semaphore free (2'b00).
- R8: Granted flag i (host address 0x19, bit i) sets when the host takes semaphore i over on a device release. It stays set until the host writes 0x19 with bit i at 1. Writing 0 to a bit has no effect, and a set in the same cycle as a clear leaves the bit set.
- R9: Host address 0x17 holds enable bits 7:0. Address 0x18 holds enable bits 10:8 in its bits 2:0, and its bits 7:3 read as 0. host_irq is 1 exactly when some granted flag i is set together with enable bit 8+i.
- R10: Every register write takes effect at the clock edge that samples it. Readback and host_irq show the new value after that edge and the old value before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register address, used for both write and read |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from host_addr |
| dev_we | input | 1 | Device register write strobe |
| dev_addr | input | 8 | Device register address, used for both write and read |
| dev_wdata | input | 8 | Device write data |
| dev_rdata | output | 8 | Device read data, combinational from dev_addr |
| host_irq | output | 1 | Host interrupt: OR of enabled granted flags |

## Verification
Every write is applied for one clock. Ownership codes, pending hand-overs, granted flags, enables and host_irq are all due right after that single edge, because the read paths are combinational from registers. Each table step therefore drops the write strobes a quarter period after the edge, moves both address buses to the step's check addresses, and compares one time unit later, well before the next edge. A directed test samples the host readback just before and just after the sampling edge to pin the one-cycle latency. Another directed test applies reset in the middle of the run and reads back every register.

// File: rtl/mbx_sema_pkg.sv
// Package: shared codes and default widths for the mailbox semaphore arbiter.
// Assumes both register ports are byte wide with an 8-bit address.
package mbx_sema_pkg;

    localparam int MBX_ADDR_W = 8;
    localparam int MBX_DATA_W = 8;
    localparam int MBX_NSEM   = 3;
    localparam int MBX_EN_LO  = 8;   // enable bits not tied to semaphores

    // Owner code as read back through either port.
    typedef enum logic [1:0] {
        SEM_FREE = 2'b00,
        SEM_HOST = 2'b01,
        SEM_DEV  = 2'b11
    } sem_code_t;

endpackage

// File: rtl/mbx_addr_decode.sv
// Module: mbx_addr_decode
// Turns the host and device write strobes into per-semaphore request and
// release commands, plus write enables for the enable and status registers.
// Assumes one write per port per cycle, and that only bits 1:0 of a
// semaphore write carry meaning.
module mbx_addr_decode
    import mbx_sema_pkg::*;
#(
    parameter int                NSEM      = MBX_NSEM,
    parameter int                ADDR_W    = MBX_ADDR_W,
    parameter int                DATA_W    = MBX_DATA_W,
    parameter logic [ADDR_W-1:0] H_SEM_BASE = 'h1C,
    parameter logic [ADDR_W-1:0] H_EN_LO    = 'h17,
    parameter logic [ADDR_W-1:0] H_EN_HI    = 'h18,
    parameter logic [ADDR_W-1:0] H_STAT     = 'h19,
    parameter logic [ADDR_W-1:0] D_SEM_BASE = 'h00
) (
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              dev_we,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [DATA_W-1:0] dev_wdata,
    output logic [NSEM-1:0]   h_req,
    output logic [NSEM-1:0]   h_rel,
    output logic [NSEM-1:0]   d_req,
    output logic [NSEM-1:0]   d_rel,
    output logic              en_lo_we,
    output logic              en_hi_we,
    output logic              stat_we
);

    logic [1:0] h_code;
    logic [1:0] d_code;

    assign h_code = host_wdata[1:0];
    assign d_code = dev_wdata[1:0];

    // Per-semaphore command strobes, one decoder slice per semaphore.
    for (genvar g = 0; g < NSEM; g++) begin : g_sem
        logic h_hit;
        logic d_hit;
        assign h_hit    = host_we && (host_addr == ADDR_W'(H_SEM_BASE + g));
        assign d_hit    = dev_we  && (dev_addr  == ADDR_W'(D_SEM_BASE + g));
        assign h_req[g] = h_hit && (h_code == SEM_HOST);
        assign h_rel[g] = h_hit && (h_code == SEM_FREE);
        assign d_req[g] = d_hit && (d_code == SEM_DEV);
        assign d_rel[g] = d_hit && (d_code == SEM_FREE);
    end

    // Host-only control registers.
    assign en_lo_we = host_we && (host_addr == H_EN_LO);
    assign en_hi_we = host_we && (host_addr == H_EN_HI);
    assign stat_we  = host_we && (host_addr == H_STAT);

endmodule

// File: rtl/mbx_sema_cell.sv
// Module: mbx_sema_cell
// Ownership state for one mailbox: current owner code plus one pending
// request flag per agent. Grants are registered. host_won marks the cycle
// whose edge hands the mailbox from the device to the host.
// Assumes request and release from one agent never arrive together.
module mbx_sema_cell
    import mbx_sema_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      h_req,
    input  logic      h_rel,
    input  logic      d_req,
    input  logic      d_rel,
    output sem_code_t owner,
    output logic      host_won
);

    sem_code_t owner_q, owner_d;
    logic      host_pend_q, host_pend_d;
    logic      dev_pend_q, dev_pend_d;

    // Next-state arbitration: free grant, pending capture, hand-over.
    always_comb begin
        owner_d     = owner_q;
        host_pend_d = host_pend_q;
        dev_pend_d  = dev_pend_q;
        host_won    = 1'b0;
        case (owner_q)
            SEM_FREE: begin
                if (h_req) begin
                    owner_d = SEM_HOST;
                    if (d_req) dev_pend_d = 1'b1;
                end else if (d_req) begin
                    owner_d = SEM_DEV;
                end
            end
            SEM_HOST: begin
                if (d_req) dev_pend_d = 1'b1;
                if (h_rel) begin
                    if (dev_pend_q || d_req) begin
                        owner_d    = SEM_DEV;
                        dev_pend_d = 1'b0;
                    end else begin
                        owner_d = SEM_FREE;
                    end
                end
            end
            SEM_DEV: begin
                if (h_req) host_pend_d = 1'b1;
                if (d_rel) begin
                    if (host_pend_q || h_req) begin
                        owner_d     = SEM_HOST;
                        host_pend_d = 1'b0;
                        host_won    = 1'b1;
                    end else begin
                        owner_d = SEM_FREE;
                    end
                end
            end
            default: begin
                owner_d = SEM_FREE;
            end
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q     <= SEM_FREE;
            host_pend_q <= 1'b0;
            dev_pend_q  <= 1'b0;
        end else begin
            owner_q     <= owner_d;
            host_pend_q <= host_pend_d;
            dev_pend_q  <= dev_pend_d;
        end
    end

    assign owner = owner_q;

    // R2: only the three defined owner codes ever appear.
    p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        owner_q != 2'b10);

    // R4: the host keeps the mailbox until it releases it.
    p_host_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == SEM_HOST && !h_rel) |=> owner_q == SEM_HOST);

    // R4: the device keeps the mailbox until it releases it.
    p_dev_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == SEM_DEV && !d_rel) |=> owner_q == SEM_DEV);

    // R4: a waiting device takes over on host release.
    p_handover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == SEM_HOST && h_rel && dev_pend_q) |=> owner_q == SEM_DEV);

    // R5: the host wins a free mailbox whenever it asks.
    p_host_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == SEM_FREE && h_req) |=> owner_q == SEM_HOST);

    // R7: an owner release with nobody waiting frees the mailbox.
    p_release_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == SEM_HOST && h_rel && !dev_pend_q && !d_req) |=> owner_q == SEM_FREE);

    // R8: a take-over pulse always leaves the host as owner.
    p_won_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_won |=> owner_q == SEM_HOST);

endmodule

// File: rtl/mbx_irq_ctrl.sv
// Module: mbx_irq_ctrl
// Holds the 11-bit interrupt enable register and the sticky granted flags,
// and forms the host interrupt. Flags set on host take-over and clear on a
// write of 1. Assumes the enables for the granted flags sit above the low
// byte, one per semaphore.
module mbx_irq_ctrl
    import mbx_sema_pkg::*;
#(
    parameter int NSEM   = MBX_NSEM,
    parameter int DATA_W = MBX_DATA_W,
    parameter int EN_LO  = MBX_EN_LO
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_lo_we,
    input  logic                  en_hi_we,
    input  logic                  stat_we,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NSEM-1:0]       won,
    output logic [EN_LO+NSEM-1:0] en_q,
    output logic [NSEM-1:0]       stat_q,
    output logic                  irq
);

    localparam int EN_W = EN_LO + NSEM;

    logic [NSEM-1:0] clr_mask;

    assign clr_mask = stat_we ? wdata[NSEM-1:0] : '0;

    // Enable register: low byte and upper semaphore enables written separately.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            if (en_lo_we) en_q[EN_LO-1:0]    <= wdata[EN_LO-1:0];
            if (en_hi_we) en_q[EN_W-1:EN_LO] <= wdata[NSEM-1:0];
        end
    end

    // Sticky granted flags: set beats write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | won;
        end
    end

    // Host interrupt from enabled granted flags.
    assign irq = |(stat_q & en_q[EN_W-1:EN_LO]);

    for (genvar g = 0; g < NSEM; g++) begin : g_chk
        // R8: a flag holds unless the host clears it.
        p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[g] && !(stat_we && wdata[g])) |=> stat_q[g]);
        // R8: a take-over always leaves its flag set, even under a clear.
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            won[g] |=> stat_q[g]);
    end

    // R9: a disabled upper enable field cannot raise the line.
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[EN_W-1:EN_LO] == '0) |-> !irq);

endmodule

// File: rtl/mbx_sema_arbiter.sv
// Module: mbx_sema_arbiter (top)
// Arbitrates three shared mailboxes between a host register port and a
// device register port. Owner codes read back combinationally from
// registered state. Assumes unmapped addresses read as zero and that writes
// to them are dropped.
module mbx_sema_arbiter
    import mbx_sema_pkg::*;
#(
    parameter int                NSEM       = MBX_NSEM,
    parameter int                ADDR_W     = MBX_ADDR_W,
    parameter int                DATA_W     = MBX_DATA_W,
    parameter int                EN_LO      = MBX_EN_LO,
    parameter logic [ADDR_W-1:0] H_SEM_BASE = 'h1C,
    parameter logic [ADDR_W-1:0] H_EN_LO    = 'h17,
    parameter logic [ADDR_W-1:0] H_EN_HI    = 'h18,
    parameter logic [ADDR_W-1:0] H_STAT     = 'h19,
    parameter logic [ADDR_W-1:0] D_SEM_BASE = 'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              dev_we,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [DATA_W-1:0] dev_wdata,
    output logic [DATA_W-1:0] dev_rdata,
    output logic              host_irq
);

    localparam int EN_W = EN_LO + NSEM;

    logic [NSEM-1:0] h_req, h_rel, d_req, d_rel, won;
    logic            en_lo_we, en_hi_we, stat_we;
    logic [EN_W-1:0] en_q;
    logic [NSEM-1:0] stat_q;
    sem_code_t       owner [NSEM];

    mbx_addr_decode #(
        .NSEM(NSEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .H_SEM_BASE(H_SEM_BASE), .H_EN_LO(H_EN_LO), .H_EN_HI(H_EN_HI),
        .H_STAT(H_STAT), .D_SEM_BASE(D_SEM_BASE)
    ) i_decode (
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .dev_we     (dev_we),
        .dev_addr   (dev_addr),
        .dev_wdata  (dev_wdata),
        .h_req      (h_req),
        .h_rel      (h_rel),
        .d_req      (d_req),
        .d_rel      (d_rel),
        .en_lo_we   (en_lo_we),
        .en_hi_we   (en_hi_we),
        .stat_we    (stat_we)
    );

    for (genvar g = 0; g < NSEM; g++) begin : g_cell
        mbx_sema_cell i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .h_req    (h_req[g]),
            .h_rel    (h_rel[g]),
            .d_req    (d_req[g]),
            .d_rel    (d_rel[g]),
            .owner    (owner[g]),
            .host_won (won[g])
        );
    end

    mbx_irq_ctrl #(
        .NSEM(NSEM), .DATA_W(DATA_W), .EN_LO(EN_LO)
    ) i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_lo_we (en_lo_we),
        .en_hi_we (en_hi_we),
        .stat_we  (stat_we),
        .wdata    (host_wdata),
        .won      (won),
        .en_q     (en_q),
        .stat_q   (stat_q),
        .irq      (host_irq)
    );

    // Host read mux: semaphores, enable halves, granted flags.
    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < NSEM; i++) begin
            if (host_addr == ADDR_W'(H_SEM_BASE + i)) host_rdata = DATA_W'(owner[i]);
        end
        if (host_addr == H_EN_LO) host_rdata = DATA_W'(en_q[EN_LO-1:0]);
        if (host_addr == H_EN_HI) host_rdata = DATA_W'(en_q[EN_W-1:EN_LO]);
        if (host_addr == H_STAT)  host_rdata = DATA_W'(stat_q);
    end

    // Device read mux: semaphores only.
    always_comb begin
        dev_rdata = '0;
        for (int i = 0; i < NSEM; i++) begin
            if (dev_addr == ADDR_W'(D_SEM_BASE + i)) dev_rdata = DATA_W'(owner[i]);
        end
    end

    // R6: a host write of an undefined code leaves every owner unchanged.
    p_bad_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == H_SEM_BASE && host_wdata[1]
         && !(dev_we && dev_addr == D_SEM_BASE))
        |=> $stable(owner[0]));

    // R1: the interrupt line is low in the first cycle after reset.
    p_irq_after_reset_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> !host_irq);

endmodule

// File: tb/test_mbx_sema_arbiter.sv
module test_mbx_sema_arbiter;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       dev_we = 1'b0;
    logic [7:0] dev_addr = '0;
    logic [7:0] dev_wdata = '0;
    logic [7:0] dev_rdata;
    logic       host_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mbx_sema_arbiter i_mbx_sema_arbiter (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .dev_we(dev_we), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .host_irq(host_irq)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       hw;  logic [7:0] ha;  logic [7:0] hd;
        logic       dw;  logic [7:0] da;  logic [7:0] dd;
        logic [7:0] hra; logic [7:0] hx;
        logic [7:0] dra; logic [7:0] dx;
        logic       irq;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{4'd3, 1'b1,8'h1C,8'h01, 1'b0,8'h00,8'h00, 8'h1C,8'h01, 8'h00,8'h01, 1'b0}, // R3 host takes 0
        '{4'd3, 1'b0,8'h00,8'h00, 1'b1,8'h01,8'h03, 8'h1D,8'h03, 8'h01,8'h03, 1'b0}, // R3 device takes 1
        '{4'd4, 1'b0,8'h00,8'h00, 1'b1,8'h00,8'h03, 8'h1C,8'h01, 8'h00,8'h01, 1'b0}, // R4 device waits on 0
        '{4'd6, 1'b0,8'h00,8'h00, 1'b1,8'h00,8'h00, 8'h1C,8'h01, 8'h00,8'h01, 1'b0}, // R6 non-owner release
        '{4'd4, 1'b1,8'h1C,8'h00, 1'b0,8'h00,8'h00, 8'h1C,8'h03, 8'h00,8'h03, 1'b0}, // R4 hand-over to device
        '{4'd4, 1'b1,8'h1D,8'h01, 1'b0,8'h00,8'h00, 8'h1D,8'h03, 8'h01,8'h03, 1'b0}, // R4 host waits on 1
        '{4'd9, 1'b1,8'h17,8'hFF, 1'b0,8'h00,8'h00, 8'h17,8'hFF, 8'h01,8'h03, 1'b0}, // R9 low enables
        '{4'd8, 1'b0,8'h00,8'h00, 1'b1,8'h01,8'h00, 8'h1D,8'h01, 8'h01,8'h01, 1'b0}, // R8 host take-over
        '{4'd8, 1'b0,8'h00,8'h00, 1'b0,8'h00,8'h00, 8'h19,8'h02, 8'h01,8'h01, 1'b0}, // R8 flag 1 set
        '{4'd9, 1'b1,8'h18,8'h02, 1'b0,8'h00,8'h00, 8'h18,8'h02, 8'h01,8'h01, 1'b1}, // R9 enable 9 -> irq
        '{4'd9, 1'b1,8'h18,8'hFF, 1'b0,8'h00,8'h00, 8'h18,8'h07, 8'h01,8'h01, 1'b1}, // R9 upper bits zero
        '{4'd8, 1'b1,8'h19,8'h01, 1'b0,8'h00,8'h00, 8'h19,8'h02, 8'h01,8'h01, 1'b1}, // R8 other bit no clear
        '{4'd8, 1'b1,8'h19,8'h02, 1'b0,8'h00,8'h00, 8'h19,8'h00, 8'h01,8'h01, 1'b0}, // R8 write-1 clear
        '{4'd6, 1'b1,8'h1D,8'h03, 1'b0,8'h00,8'h00, 8'h1D,8'h01, 8'h01,8'h01, 1'b0}, // R6 host code 11
        '{4'd6, 1'b0,8'h00,8'h00, 1'b1,8'h02,8'h01, 8'h1E,8'h00, 8'h02,8'h00, 1'b0}, // R6 device code 01
        '{4'd7, 1'b1,8'h1D,8'h00, 1'b0,8'h00,8'h00, 8'h1D,8'h00, 8'h01,8'h00, 1'b0}, // R7 host frees 1
        '{4'd7, 1'b0,8'h00,8'h00, 1'b1,8'h00,8'h00, 8'h1C,8'h00, 8'h00,8'h00, 1'b0}, // R7 device frees 0
        '{4'd5, 1'b1,8'h1E,8'h01, 1'b1,8'h02,8'h03, 8'h1E,8'h01, 8'h02,8'h01, 1'b0}, // R5 tie, host wins
        '{4'd5, 1'b1,8'h1E,8'h00, 1'b0,8'h00,8'h00, 8'h1E,8'h03, 8'h02,8'h03, 1'b0}, // R5 device was pending
        '{4'd2, 1'b1,8'h1F,8'hFF, 1'b0,8'h00,8'h00, 8'h1F,8'h00, 8'h05,8'h00, 1'b0}, // R2 unmapped reads 0
        '{4'd2, 1'b1,8'h1C,8'hFD, 1'b0,8'h00,8'h00, 8'h1C,8'h01, 8'h00,8'h01, 1'b0}, // R2 high bits ignored
        '{4'd4, 1'b1,8'h1E,8'h01, 1'b0,8'h00,8'h00, 8'h1E,8'h03, 8'h02,8'h03, 1'b0}, // R4 host waits on 2
        '{4'd8, 1'b1,8'h19,8'h04, 1'b1,8'h02,8'h00, 8'h19,8'h04, 8'h02,8'h01, 1'b1}  // R8 set beats clear
    };

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic host_read(input string tag, input logic [7:0] a, input logic [7:0] exp);
        host_addr = a;
        #1;
        check8(tag, host_rdata, exp);
    endtask

    // Directed: everything back at zero (R1).
    task automatic check_reset_state();
        dev_addr = 8'h00;
        for (int i = 0; i < 3; i++) host_read("R1 sema", 8'h1C + 8'(i), 8'h00);
        host_read("R1 en_lo", 8'h17, 8'h00);
        host_read("R1 en_hi", 8'h18, 8'h00);
        host_read("R1 flags", 8'h19, 8'h00);
        check8("R1 dev sema0", dev_rdata, 8'h00);
        check8("R1 irq", {7'd0, host_irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check_reset_state();
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk.
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            host_we = VEC[k].hw; host_addr = VEC[k].ha; host_wdata = VEC[k].hd;
            dev_we  = VEC[k].dw; dev_addr  = VEC[k].da; dev_wdata  = VEC[k].dd;
            @(posedge clk);
            #(CLK_P/4);
            host_we = 1'b0; dev_we = 1'b0;
            host_addr = VEC[k].hra; dev_addr = VEC[k].dra;
            #1;
            n_chk++;
            if (host_rdata !== VEC[k].hx) begin
                n_bad++;
                $display("FAIL R%0d step %0d host actual=%02h expected=%02h",
                         VEC[k].req, k, host_rdata, VEC[k].hx);
            end
            n_chk++;
            if (dev_rdata !== VEC[k].dx) begin
                n_bad++;
                $display("FAIL R%0d step %0d dev actual=%02h expected=%02h",
                         VEC[k].req, k, dev_rdata, VEC[k].dx);
            end
            n_chk++;
            if (host_irq !== VEC[k].irq) begin
                n_bad++;
                $display("FAIL R%0d step %0d irq actual=%0b expected=%0b",
                         VEC[k].req, k, host_irq, VEC[k].irq);
            end
        end

        // Directed: reset in mid-run clears state and irq (R1).
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #(CLK_P/4);
        check_reset_state();
        @(negedge clk);
        rst_n = 1'b1;

        // Directed: one-cycle latency of a grant (R10).
        @(negedge clk);
        host_we = 1'b1; host_addr = 8'h1C; host_wdata = 8'h01;
        #1;
        check8("R10 before edge", host_rdata, 8'h00);
        @(posedge clk);
        #(CLK_P/4);
        host_we = 1'b0;
        #1;
        check8("R10 after edge", host_rdata, 8'h01);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule